// File: doc/BRIEF.md
# Reciprocal Dual-Accumulator Counter

This block measures a signal on channel A by running two 32-bit binary accumulators over one shared gate interval. One accumulator counts channel A rising edges. The other counts either system clock cycles, which are the reference timebase, or channel B rising edges when ratio mode is selected. The gate opens and closes only on channel A rising edges, so each measurement covers a whole number of channel A periods. The host reads both raw counts and does the division itself. Frequency is events over time, period is time over events, and the ratio is B events over A events.

The host starts a measurement by raising `gate_req`. A measurement ends in one of three ways: the channel A count reaches an averaging threshold of 10^N, the host withdraws the request, or, in automatic mode, a programmed gate time runs out. In each case the gate shuts at the next channel A edge. A one-cycle `done` pulse marks the end, and the counts then hold until the next start.

The controller is a five-state machine:
- IDLE waits for a rising edge on the request.
- ARM waits for the opening channel A edge. It returns to IDLE if the request is withdrawn.
- MEAS counts.
- DRAIN keeps counting after a stop has been called, until the closing edge arrives.
- FIN raises `done` for one cycle and then returns to IDLE.

Transitions:
- IDLE→ARM on a request rise.
- ARM→MEAS on an A edge; this also clears both accumulators.
- ARM→IDLE on cancel.
- MEAS→FIN on an A edge that either meets the threshold or finds a stop pending.
- MEAS→DRAIN on a stop with no A edge in the same cycle.
- DRAIN→FIN on an A edge.
- FIN→IDLE unconditionally.

Top module: `recip_counter`

## Requirements
- R1: Reset clears both accumulators and leaves `gate_open`, `busy` and `done` low.
- R2: A rising edge on `gate_req` does not open the gate at once. The gate opens at the next synchronized channel A rising edge, and both accumulators keep their previous values until that edge.
- R3: While the gate is open, `acc_a` increments once for each channel A rising edge after the opening edge, up to and including the closing edge.
- R4: With `ratio_mode`=0, `acc_b` increments once per clock cycle while the gate is open. A measurement over k channel A periods of P cycles each therefore ends with `acc_b` = k·P.
- R5: With `ratio_mode`=1, `acc_b` counts the channel B rising edges that occur after the opening A edge, up to and including the closing A edge.
- R6: With `auto_mode`=0, the gate closes at the channel A edge that brings `acc_a` to 10^N, where N = `avg_exp` (0 to 9). N=0 gives a single period.
- R7: Dropping `gate_req` while the gate is open closes the gate at the next channel A rising edge, and that edge is counted.
- R8: With `auto_mode`=1, `avg_exp` is ignored. The gate closes at the first channel A edge after it has been open for `AUTO_CYCLES` clock cycles.
- R9: `done` is high for exactly one cycle, immediately after the gate closes, and `gate_open` is low while `done` is high.
- R10: While the gate is closed, the accumulators hold their values whatever activity appears on channel A or channel B.
- R11: Dropping `gate_req` before the opening edge returns the block to idle. No `done` is produced and the accumulators are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the reference timebase |
| rst_n | input | 1 | Active-low reset |
| chan_a | input | 1 | Asynchronous channel A signal |
| chan_b | input | 1 | Asynchronous channel B signal |
| gate_req | input | 1 | Host measurement request; a rise starts, a fall stops |
| ratio_mode | input | 1 | 1: accumulator B counts channel B edges; 0: clock cycles |
| auto_mode | input | 1 | 1: stop on gate time; 0: stop on the 10^N threshold |
| avg_exp | input | 4 | Averaging exponent N (values above 9 act as 9) |
| acc_a | output | 32 | Channel A event count |
| acc_b | output | 32 | Time or channel B event count |
| gate_open | output | 1 | High while the accumulators run |
| busy | output | 1 | High from request until end of measurement |
| done | output | 1 | One-cycle pulse at end of measurement |

## Verification
The main function is exercised with periodic channel A waveforms whose period and phase are randomized, in both time mode and ratio mode. Ratio mode uses a channel B whose period is unrelated to channel A's, so channel B edges land at many different offsets from the window boundaries. This separates correct from off-by-one inclusion of edges that coincide with the opening or closing A edge. Directed runs cover:
- N=0, which shows the first edge after opening already closes the gate.
- A request withdrawn mid-measurement, which separates edge-aligned closing from immediate closing.
- Automatic mode with N=0, which shows the time limit rather than the threshold ends the run.
- A request cancelled before opening.

// File: rtl/recip_pkg.sv
package recip_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_MEAS,
        ST_DRAIN,
        ST_FIN
    } gate_state_t;

    localparam int unsigned MAX_EXP = 9;

    // 10^n with n limited to MAX_EXP so the result fits 32 bits
    function automatic logic [31:0] pow10_limited(input logic [3:0] n);
        logic [31:0] v;
        int unsigned lim;
        lim = (n > MAX_EXP) ? MAX_EXP : int'(n);
        v = 32'd1;
        for (int unsigned k = 0; k < MAX_EXP; k++) begin
            if (k < lim) v = v * 32'd10;
        end
        return v;
    endfunction

endpackage

// File: rtl/recip_edge_sync.sv
module recip_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_async,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              last_q;

    generate
        for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain[gi] <= 1'b0;
                end else if (gi == 0) begin
                    chain[gi] <= sig_async;
                end else begin
                    chain[gi] <= chain[(gi == 0) ? 0 : gi-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain[STAGES-1];
    end

    assign rise = chain[STAGES-1] & ~last_q;
endmodule

// File: rtl/recip_accum.sv
module recip_accum #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [WIDTH-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   count <= '0;
        else if (clr) count <= '0;
        else if (inc) count <= count + 1'b1;
    end
endmodule

// File: rtl/recip_gate_fsm.sv
module recip_gate_fsm
    import recip_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int AUTO_CYCLES = 96_000_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gate_req,
    input  logic             auto_mode,
    input  logic [3:0]       avg_exp,
    input  logic             a_rise,
    input  logic [CNT_W-1:0] acc_a,
    output logic             acc_clr,
    output logic             run,
    output logic             busy,
    output logic             done
);
    localparam int TMR_W = $clog2(AUTO_CYCLES + 1);
    localparam logic [TMR_W-1:0] TMR_LIMIT = TMR_W'(AUTO_CYCLES);

    gate_state_t      state_q, state_d;
    logic             req_q;
    logic             req_rise;
    logic [TMR_W-1:0] timer_q;
    logic [CNT_W-1:0] thresh_q;
    logic             thr_hit;
    logic             time_hit;
    logic             stop_now;

    assign req_rise = gate_req & ~req_q;
    assign thr_hit  = ~auto_mode &
                      (({1'b0, acc_a} + {{CNT_W{1'b0}}, 1'b1}) >= {1'b0, thresh_q});
    assign time_hit = auto_mode & (timer_q >= TMR_LIMIT);
    assign stop_now = ~gate_req | time_hit;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_rise) state_d = ST_ARM;
            ST_ARM: begin
                if (!gate_req)   state_d = ST_IDLE;
                else if (a_rise) state_d = ST_MEAS;
            end
            ST_MEAS: begin
                if (a_rise && (thr_hit || stop_now)) state_d = ST_FIN;
                else if (stop_now)                   state_d = ST_DRAIN;
            end
            ST_DRAIN: if (a_rise) state_d = ST_FIN;
            ST_FIN:   state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        acc_clr = 1'b0;
        run     = 1'b0;
        busy    = 1'b1;
        done    = 1'b0;
        unique case (state_q)
            ST_IDLE:  busy    = 1'b0;
            ST_ARM:   acc_clr = gate_req & a_rise;
            ST_MEAS:  run     = 1'b1;
            ST_DRAIN: run     = 1'b1;
            ST_FIN:   done    = 1'b1;
            default:  busy    = 1'b0;
        endcase
    end

    // request edge, gate timer, latched threshold
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q    <= 1'b0;
            timer_q  <= '0;
            thresh_q <= CNT_W'(1);
        end else begin
            req_q <= gate_req;
            if (acc_clr) begin
                timer_q  <= '0;
                thresh_q <= CNT_W'(pow10_limited(avg_exp));
            end else if (run && (timer_q < TMR_LIMIT)) begin
                timer_q <= timer_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/recip_counter.sv
module recip_counter
    import recip_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2,
    parameter int AUTO_CYCLES = 96_000_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chan_a,
    input  logic             chan_b,
    input  logic             gate_req,
    input  logic             ratio_mode,
    input  logic             auto_mode,
    input  logic [3:0]       avg_exp,
    output logic [CNT_W-1:0] acc_a,
    output logic [CNT_W-1:0] acc_b,
    output logic             gate_open,
    output logic             busy,
    output logic             done
);
    localparam int N_CH = 2;

    logic [N_CH-1:0] ch_raw;
    logic [N_CH-1:0] ch_rise;
    logic            acc_clr;
    logic            run;
    logic            inc_a;
    logic            inc_b;

    assign ch_raw = {chan_b, chan_a};

    generate
        for (genvar ci = 0; ci < N_CH; ci++) begin : g_sync
            recip_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk       (clk),
                .rst_n     (rst_n),
                .sig_async (ch_raw[ci]),
                .rise      (ch_rise[ci])
            );
        end
    endgenerate

    recip_gate_fsm #(.CNT_W(CNT_W), .AUTO_CYCLES(AUTO_CYCLES)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .gate_req  (gate_req),
        .auto_mode (auto_mode),
        .avg_exp   (avg_exp),
        .a_rise    (ch_rise[0]),
        .acc_a     (acc_a),
        .acc_clr   (acc_clr),
        .run       (run),
        .busy      (busy),
        .done      (done)
    );

    assign inc_a = run & ch_rise[0];
    assign inc_b = run & (ratio_mode ? ch_rise[1] : 1'b1);

    recip_accum #(.WIDTH(CNT_W)) u_acc_a (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (acc_clr),
        .inc   (inc_a),
        .count (acc_a)
    );

    recip_accum #(.WIDTH(CNT_W)) u_acc_b (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (acc_clr),
        .inc   (inc_b),
        .count (acc_b)
    );

    assign gate_open = run;
endmodule

// File: rtl/recip_counter_chk.sv
module recip_counter_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ratio_mode,
    input logic [CNT_W-1:0] acc_a,
    input logic [CNT_W-1:0] acc_b,
    input logic             gate_open,
    input logic             done
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (acc_a == '0) && (acc_b == '0) && !done && !gate_open);

    assert_a_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(gate_open) |-> ((acc_a - $past(acc_a)) <= CNT_W'(1)));

    assert_time_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(gate_open) && !$past(ratio_mode)) |-> (acc_b == $past(acc_b) + CNT_W'(1)));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(gate_open) && !gate_open));

    assert_hold_closed_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_open && !$past(gate_open)) |-> ($stable(acc_a) && $stable(acc_b)));
endmodule

bind recip_counter recip_counter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ratio_mode (ratio_mode),
    .acc_a      (acc_a),
    .acc_b      (acc_b),
    .gate_open  (gate_open),
    .done       (done)
);

// File: tb/test_recip_counter.sv
`timescale 1ns/1ps
module test_recip_counter;
    localparam int AUTO = 300;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chan_a = 1'b0, chan_b = 1'b0, gate_req = 1'b0;
    logic        ratio_mode = 1'b0, auto_mode = 1'b0;
    logic [3:0]  avg_exp = 4'd0;
    logic [31:0] acc_a, acc_b;
    logic        gate_open, busy, done;

    int n = 0;
    int pa = 8, pha = 0, pb = 5, phb = 0;
    int req_on_at = -1, req_off_at = -1;
    int vectors = 0, miscompares = 0;

    always #2.5 clk = ~clk;

    recip_counter #(.AUTO_CYCLES(AUTO)) i_recip_counter (
        .clk(clk), .rst_n(rst_n), .chan_a(chan_a), .chan_b(chan_b),
        .gate_req(gate_req), .ratio_mode(ratio_mode), .auto_mode(auto_mode),
        .avg_exp(avg_exp), .acc_a(acc_a), .acc_b(acc_b),
        .gate_open(gate_open), .busy(busy), .done(done));

    // stimulus driver: all inputs change on the falling edge
    always @(negedge clk) begin
        n = n + 1;
        chan_a = ((n + pha) % pa) < (pa / 2);
        chan_b = ((n + phb) % pb) < (pb / 2);
        if (n == req_on_at)  gate_req = 1'b1;
        if (n == req_off_at) gate_req = 1'b0;
    end

    function automatic int next_rise(int after, int p, int ph);
        int r;
        r = (after + ph) % p;
        return after + p - r;
    endfunction

    function automatic int rises_in(int lo, int hi, int p, int ph);
        return ((hi + ph) / p) - ((lo + ph) / p);
    endfunction

    function automatic int pow10(int e);
        int v = 1;
        for (int k = 0; k < e; k++) v = v * 10;
        return v;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // first mid-phase cycle of channel A at least two cycles ahead
    function automatic int mid_after(int cur);
        int s = cur + 2;
        while (((s + pha) % pa) != (pa / 2)) s++;
        return s;
    endfunction

    task automatic wait_done(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 20000; i++) begin
            tick();
            if (done) begin seen = 1'b1; break; end
        end
    endtask

    // drop_k = 0: end by threshold or timer; otherwise drop after drop_k periods
    task automatic measure(input bit ratio, input bit automode, input int nexp, input int drop_k);
        int s, n_open, n_close, k;
        logic [31:0] old_a, old_b;
        bit seen;
        ratio_mode = ratio; auto_mode = automode; avg_exp = 4'(nexp);
        old_a = acc_a; old_b = acc_b;
        tick();
        s = mid_after(n);
        req_on_at = s;
        n_open = next_rise(s, pa, pha);
        if (drop_k > 0) begin
            req_off_at = n_open + drop_k * pa + pa / 2;
            k = drop_k + 1;
        end else begin
            k = pow10(nexp);
        end
        n_close = n_open + k * pa;
        while (n < s + 1) tick();
        check(!gate_open && acc_a == old_a && acc_b == old_b, "R2", acc_a, old_a);
        wait_done(seen);
        check(seen, "R9 done", seen, 1);
        if (!seen) return;
        check(!gate_open, "R9 gate_open", gate_open, 0);
        if (automode) begin
            check(acc_b == acc_a * pa, "R8 whole periods", acc_b, acc_a * pa);
            check(acc_b >= AUTO && acc_b < AUTO + pa + 2, "R8 limit", acc_b, AUTO);
        end else begin
            check(acc_a == k, drop_k > 0 ? "R7 count" : "R6/R3 count", acc_a, k);
            if (ratio)
                check(acc_b == rises_in(n_open, n_close, pb, phb), "R5 ratio", acc_b,
                      rises_in(n_open, n_close, pb, phb));
            else
                check(acc_b == k * pa, "R4 time", acc_b, k * pa);
        end
        tick();
        check(!done, "R9 one cycle", done, 0);
        req_off_at = n + 1;
        old_a = acc_a; old_b = acc_b;
        for (int i = 0; i < 3 * pa; i++) tick();
        check(acc_a == old_a && acc_b == old_b && !gate_open, "R10 hold", acc_b, old_b);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) tick();
        check(acc_a == 0 && acc_b == 0 && !gate_open && !busy && !done, "R1 reset", acc_a, 0);
        rst_n = 1'b1;
        repeat (4) tick();
        check(acc_a == 0 && acc_b == 0 && !done, "R1 after release", acc_b, 0);

        // directed: single period
        pa = 10; pha = 3;
        repeat (4) tick();
        measure(1'b0, 1'b0, 0, 0);
        // directed: host stop mid-run
        measure(1'b0, 1'b0, 9, 5);
        measure(1'b1, 1'b0, 9, 3);
        // directed: auto mode ignores N=0
        measure(1'b0, 1'b1, 0, 0);
        check(acc_a > 1, "R8 N ignored", acc_a, 2);

        // directed: cancel before opening
        begin
            logic [31:0] oa, ob;
            bit hit;
            int s;
            oa = acc_a; ob = acc_b; hit = 1'b0;
            tick();
            s = mid_after(n);
            req_on_at = s; req_off_at = s + 1;
            for (int i = 0; i < 4 * pa; i++) begin
                tick();
                if (done || gate_open) hit = 1'b1;
            end
            check(!hit && !busy && acc_a == oa && acc_b == ob, "R11 cancel", acc_a, oa);
        end

        // random trials
        for (int t = 0; t < 16; t++) begin
            pa = 2 * (2 + int'($urandom % 15));
            pha = int'($urandom % 64);
            pb = 3 + int'($urandom % 20);
            phb = int'($urandom % 64);
            repeat (4) tick();
            measure(1'($urandom % 2), 1'b0, int'($urandom % 3), 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        miscompares++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule